// File: doc/BRIEF.md
# ECC-Protected Byte-Writable SRAM Controller

This block fronts a single-port on-chip storage array and serves it to a 128-bit system bus. The block keeps the contents in 64-bit words. Each word is stored with eight check bits of a single-error-correct, double-error-detect code. One bus beat therefore covers two protected words, called lanes. A request handshake (valid/ready) carries reads and writes. A write may carry any pattern of byte enables. A read returns the corrected beat one registered cycle after the array read, together with pulse flags for corrected and uncorrectable errors.

The controller writes a lane whose eight bytes are all enabled straight into the array, with no stall. It leaves a lane with no bytes enabled untouched. A lane with only some bytes enabled needs the old word, so the controller turns the write into an internal sequence: read, correct, merge the new bytes, re-encode, write. Ready drops for the extra cycle. The sequence is cancelled when the old word of a partly written lane cannot be corrected.

The controller decodes its window from a base address input, aligned to the window size. A request outside the window is accepted but does nothing.

Top module: `ecc_sram_ctrl`

## Requirements
- R1: Every stored 64-bit word carries 8 check bits (Hamming positions plus overall parity), and a beat written with all 16 byte enables set reads back unchanged.
- R2: A write honours any byte-enable pattern. Bit b of the enable mask selects byte b (bits 8b+7..8b) of the beat. Bytes whose enable is clear keep their previous contents.
- R3: A write in which each lane (bytes 0-7 are lane 0, bytes 8-15 are lane 1) is either fully enabled or fully disabled completes on the accepting edge. Ready stays high in the next cycle and no error flag is raised.
- R4: A write that has at least one lane partly enabled holds ready low for exactly one cycle after the accepting edge, and then ready returns high.
- R5: A read accepted on edge k holds ready low for the cycle after k, and gives one cycle of rsp_valid_o with the data after edge k+1.
- R6: A single flipped bit in a stored word, whether a data, check or overall-parity bit, is corrected in the read data and pulses ecc_corr_o with that response. The corrected value is not written back, so a second read flags it again.
- R7: Two flipped bits in one stored word pulse ecc_uncorr_o with the read response. The other lane's data is still returned correctly.
- R8: If the internal read of a partial write finds an uncorrectable word in a partly enabled lane, nothing of the beat is written, and ecc_uncorr_o pulses after the second edge following acceptance.
- R9: If that internal read finds a correctable error in a partly enabled lane, the corrected word is merged and re-encoded. ecc_corr_o pulses after the second edge, and later reads of the beat are clean.
- R10: A request whose address differs from cfg_base_i in the bits above the window (window = DEPTH x 16 bytes) is accepted with ready staying high. It changes no storage and produces no response or flag. Moving the base moves the window over the same contents.
- R11: During reset, ready is high and rsp_valid_o, ecc_corr_o and ecc_uncorr_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_base_i | input | ADDR_W | Window base address, only bits above the window size are used |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address of the beat |
| req_be_i | input | DATA_W/8 | Byte enables of a write |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle |
| rsp_rdata_o | output | DATA_W | Corrected read data |
| ecc_corr_o | output | 1 | Correctable error seen (read or internal read) |
| ecc_uncorr_o | output | 1 | Uncorrectable error seen (read or internal read) |

## Verification
Each result has a fixed time after the accepting edge. Read data and its flags appear after the second edge, and the flags of a partial write appear after the second edge as well. The ready level after the first edge tells whether the request stalled. The driver changes inputs on falling edges. After each accepting edge it checks ready and the absence of a response at the next falling edge, and it checks the response at the falling edge after that. The monitor takes the results at falling edges from an in-order queue of expected items, so a result that comes early, late or unasked is reported.

// File: rtl/sram_ecc_pkg.sv
package sram_ecc_pkg;

   // number of Hamming position bits needed for a data word of width w
   function automatic int secded_pbits(input int w);
      int p;
      p = 1;
      while ((1 << p) < (w + p + 1)) p++;
      return p;
   endfunction

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_RMW  = 2'd2
   } ctrl_state_e;

endpackage

// File: rtl/sram_secded_enc.sv
module sram_secded_enc #(
   parameter int WORD_W = 64,
   localparam int P_W   = sram_ecc_pkg::secded_pbits(WORD_W),
   localparam int CW_W  = WORD_W + P_W + 1
) (
   input  logic [WORD_W-1:0] data_i,
   output logic [CW_W-1:0]   code_o
);

   logic [CW_W-1:0] cw;
   int              d;
   logic            par;

   always_comb begin
      cw  = '0;
      d   = 0;
      par = 1'b0;
      // scatter data over the non power-of-two positions
      for (int pos = 1; pos < CW_W; pos++) begin
         if ((pos & (pos - 1)) != 0) begin
            cw[pos] = data_i[d];
            d++;
         end
      end
      // each position bit p gets even parity over positions that have bit p set
      for (int p = 0; p < P_W; p++) begin
         par = 1'b0;
         for (int pos = 1; pos < CW_W; pos++) begin
            if ((((pos >> p) & 1) == 1) && (pos != (1 << p))) par ^= cw[pos];
         end
         cw[1 << p] = par;
      end
      cw[0]  = ^cw[CW_W-1:1];
      code_o = cw;
   end

endmodule

// File: rtl/sram_secded_dec.sv
module sram_secded_dec #(
   parameter int WORD_W = 64,
   localparam int P_W   = sram_ecc_pkg::secded_pbits(WORD_W),
   localparam int CW_W  = WORD_W + P_W + 1
) (
   input  logic [CW_W-1:0]   code_i,
   output logic [WORD_W-1:0] data_o,
   output logic              single_o,
   output logic              double_o
);

   logic [P_W-1:0]  syn;
   logic            overall;
   logic [CW_W-1:0] fixed;
   int              d;

   always_comb begin
      syn      = '0;
      overall  = ^code_i;
      fixed    = code_i;
      single_o = 1'b0;
      double_o = 1'b0;
      data_o   = '0;
      d        = 0;
      for (int pos = 1; pos < CW_W; pos++) begin
         if (code_i[pos]) syn ^= pos[P_W-1:0];
      end
      if (overall) begin
         if (int'(syn) < CW_W) begin
            fixed[syn] = ~fixed[syn];
            single_o   = 1'b1;
         end else begin
            double_o   = 1'b1;
         end
      end else if (syn != '0) begin
         double_o = 1'b1;
      end
      for (int pos = 1; pos < CW_W; pos++) begin
         if ((pos & (pos - 1)) != 0) begin
            data_o[d] = fixed[pos];
            d++;
         end
      end
   end

endmodule

// File: rtl/sram_word_array.sv
module sram_word_array #(
   parameter int DEPTH = 64,
   parameter int LANES = 2,
   parameter int CW_W  = 72,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                  clk_i,
   input  logic                  rd_i,
   input  logic [LANES-1:0]      we_i,
   input  logic [IDX_W-1:0]      idx_i,
   input  logic [LANES*CW_W-1:0] wdata_i,
   output logic [LANES*CW_W-1:0] rdata_o
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [CW_W-1:0] mem_q [DEPTH];

      always_ff @(posedge clk_i) begin
         if (we_i[l]) begin
            mem_q[idx_i] <= wdata_i[l*CW_W +: CW_W];
         end else if (rd_i) begin
            rdata_o[l*CW_W +: CW_W] <= mem_q[idx_i];
         end
      end
   end

endmodule

// File: rtl/ecc_sram_ctrl.sv
module ecc_sram_ctrl
   import sram_ecc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 128,
   parameter int WORD_W = 64,
   parameter int DEPTH  = 64
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [ADDR_W-1:0]   cfg_base_i,
   input  logic                req_valid_i,
   output logic                req_ready_o,
   input  logic                req_write_i,
   input  logic [ADDR_W-1:0]   req_addr_i,
   input  logic [DATA_W/8-1:0] req_be_i,
   input  logic [DATA_W-1:0]   req_wdata_i,
   output logic                rsp_valid_o,
   output logic [DATA_W-1:0]   rsp_rdata_o,
   output logic                ecc_corr_o,
   output logic                ecc_uncorr_o
);

   localparam int LANES      = DATA_W / WORD_W;
   localparam int LANE_BYTES = WORD_W / 8;
   localparam int BEAT_BYTES = DATA_W / 8;
   localparam int OFF_W      = $clog2(BEAT_BYTES);
   localparam int IDX_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int TAG_LSB    = OFF_W + IDX_W;
   localparam int P_W        = secded_pbits(WORD_W);
   localparam int CW_W       = WORD_W + P_W + 1;

   // elaboration-time parameter checks
   if (WORD_W % 8 != 0) begin : g_chk_word
      $error("WORD_W must be a whole number of bytes");
   end
   if (DATA_W % WORD_W != 0) begin : g_chk_lanes
      $error("DATA_W must be a multiple of WORD_W");
   end
   if ((1 << IDX_W) != DEPTH) begin : g_chk_depth
      $error("DEPTH must be a power of two");
   end
   if (TAG_LSB >= ADDR_W) begin : g_chk_addr
      $error("window does not fit in the address width");
   end

   ctrl_state_e             state_q, state_d;
   logic [IDX_W-1:0]        hold_idx_q;
   logic [BEAT_BYTES-1:0]   hold_be_q;
   logic [DATA_W-1:0]       hold_wdata_q;

   logic                    hit, accept;
   logic [IDX_W-1:0]        req_idx;
   logic                    addr_lsb_unused;

   logic [LANES-1:0]        lane_full, lane_part;
   logic [LANES-1:0]        hold_full, hold_part;
   logic [LANES-1:0]        dec_single, dec_double;
   logic [DATA_W-1:0]       dec_word;
   logic [DATA_W-1:0]       merged_word;
   logic [LANES*CW_W-1:0]   enc_word;
   logic [LANES*CW_W-1:0]   arr_rdata;

   logic                    arr_rd;
   logic [LANES-1:0]        arr_we;
   logic [IDX_W-1:0]        arr_idx;
   logic                    rmw_abort;

   // window decode
   assign hit     = req_addr_i[ADDR_W-1:TAG_LSB] == cfg_base_i[ADDR_W-1:TAG_LSB];
   assign req_idx = req_addr_i[OFF_W +: IDX_W];
   assign addr_lsb_unused = ^{req_addr_i[OFF_W-1:0], cfg_base_i[TAG_LSB-1:0]};

   assign req_ready_o = (state_q == ST_IDLE);
   assign accept      = req_valid_i && req_ready_o;

   // per-lane coding, byte merge and enable classification
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_BYTES-1:0] be_now, be_held;
      logic [WORD_W-1:0]     enc_in;

      assign be_now       = req_be_i[l*LANE_BYTES +: LANE_BYTES];
      assign be_held      = hold_be_q[l*LANE_BYTES +: LANE_BYTES];
      assign lane_full[l] = &be_now;
      assign lane_part[l] = (|be_now) && !(&be_now);
      assign hold_full[l] = &be_held;
      assign hold_part[l] = (|be_held) && !(&be_held);

      sram_secded_dec #(.WORD_W(WORD_W)) u_dec (
         .code_i   (arr_rdata[l*CW_W +: CW_W]),
         .data_o   (dec_word[l*WORD_W +: WORD_W]),
         .single_o (dec_single[l]),
         .double_o (dec_double[l])
      );

      for (genvar b = 0; b < LANE_BYTES; b++) begin : g_byte
         localparam int BIT0 = l*WORD_W + b*8;
         assign merged_word[BIT0 +: 8] = be_held[b] ? hold_wdata_q[BIT0 +: 8]
                                                    : dec_word[BIT0 +: 8];
      end

      assign enc_in = (state_q == ST_RMW) ? merged_word[l*WORD_W +: WORD_W]
                                          : req_wdata_i[l*WORD_W +: WORD_W];

      sram_secded_enc #(.WORD_W(WORD_W)) u_enc (
         .data_i (enc_in),
         .code_o (enc_word[l*CW_W +: CW_W])
      );
   end

   assign rmw_abort = |(hold_part & dec_double);

   // sequencing of array accesses
   always_comb begin
      state_d = state_q;
      arr_rd  = 1'b0;
      arr_we  = '0;
      arr_idx = req_idx;
      unique case (state_q)
         ST_IDLE: begin
            if (accept && hit) begin
               if (!req_write_i) begin
                  arr_rd  = 1'b1;
                  state_d = ST_RD;
               end else if (|lane_part) begin
                  arr_rd  = 1'b1;
                  state_d = ST_RMW;
               end else begin
                  arr_we  = lane_full;
               end
            end
         end
         ST_RD: begin
            state_d = ST_IDLE;
         end
         ST_RMW: begin
            arr_idx = hold_idx_q;
            if (!rmw_abort) arr_we = hold_full | hold_part;
            state_d = ST_IDLE;
         end
         default: begin
            state_d = ST_IDLE;
         end
      endcase
   end

   sram_word_array #(
      .DEPTH (DEPTH),
      .LANES (LANES),
      .CW_W  (CW_W)
   ) u_array (
      .clk_i   (clk_i),
      .rd_i    (arr_rd),
      .we_i    (arr_we),
      .idx_i   (arr_idx),
      .wdata_i (enc_word),
      .rdata_o (arr_rdata)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q      <= ST_IDLE;
         hold_idx_q   <= '0;
         hold_be_q    <= '0;
         hold_wdata_q <= '0;
      end else begin
         state_q <= state_d;
         if (accept && hit && req_write_i) begin
            hold_idx_q   <= req_idx;
            hold_be_q    <= req_be_i;
            hold_wdata_q <= req_wdata_i;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rsp_valid_o  <= 1'b0;
         rsp_rdata_o  <= '0;
         ecc_corr_o   <= 1'b0;
         ecc_uncorr_o <= 1'b0;
      end else begin
         rsp_valid_o  <= (state_q == ST_RD);
         if (state_q == ST_RD) rsp_rdata_o <= dec_word;
         ecc_corr_o   <= ((state_q == ST_RD)  && |dec_single) ||
                         ((state_q == ST_RMW) && |(hold_part & dec_single));
         ecc_uncorr_o <= ((state_q == ST_RD)  && |dec_double) ||
                         ((state_q == ST_RMW) && rmw_abort);
      end
   end

endmodule

// File: rtl/sram_ecc_ctrl_chk.sv
module sram_ecc_ctrl_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 128,
   parameter int WORD_W = 64,
   parameter int DEPTH  = 64
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic [ADDR_W-1:0]   cfg_base_i,
   input logic                req_valid_i,
   input logic                req_ready_o,
   input logic                req_write_i,
   input logic [ADDR_W-1:0]   req_addr_i,
   input logic [DATA_W/8-1:0] req_be_i,
   input logic                rsp_valid_o,
   input logic                ecc_corr_o,
   input logic                ecc_uncorr_o
);

   localparam int LANES      = DATA_W / WORD_W;
   localparam int LANE_BYTES = WORD_W / 8;
   localparam int OFF_W      = $clog2(DATA_W / 8);
   localparam int IDX_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int TAG_LSB    = OFF_W + IDX_W;

   logic in_win, any_part, acc;
   logic chk_lsb_unused;

   assign in_win = req_addr_i[ADDR_W-1:TAG_LSB] == cfg_base_i[ADDR_W-1:TAG_LSB];
   assign acc    = req_valid_i && req_ready_o;
   assign chk_lsb_unused = ^{req_addr_i[TAG_LSB-1:0], cfg_base_i[TAG_LSB-1:0]};

   always_comb begin
      any_part = 1'b0;
      for (int l = 0; l < LANES; l++) begin
         if ((|req_be_i[l*LANE_BYTES +: LANE_BYTES]) && !(&req_be_i[l*LANE_BYTES +: LANE_BYTES]))
            any_part = 1'b1;
      end
   end

   assert_full_write_nostall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc && in_win && req_write_i && !any_part) |=> (req_ready_o && !ecc_corr_o && !ecc_uncorr_o));

   assert_partial_write_stall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc && in_win && req_write_i && any_part) |=> !req_ready_o ##1 req_ready_o);

   assert_read_stall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc && in_win && !req_write_i) |=> !req_ready_o);

   assert_read_response_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc && in_win && !req_write_i) |=> ##1 rsp_valid_o);

   assert_response_after_stall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_valid_o |-> $past(!req_ready_o));

   assert_corr_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ecc_corr_o |=> !ecc_corr_o);

   assert_uncorr_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ecc_uncorr_o |=> !ecc_uncorr_o);

   assert_outside_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc && !in_win) |=> req_ready_o ##1 (!rsp_valid_o && !ecc_corr_o && !ecc_uncorr_o));

endmodule

bind ecc_sram_ctrl sram_ecc_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .WORD_W (WORD_W),
   .DEPTH  (DEPTH)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .cfg_base_i   (cfg_base_i),
   .req_valid_i  (req_valid_i),
   .req_ready_o  (req_ready_o),
   .req_write_i  (req_write_i),
   .req_addr_i   (req_addr_i),
   .req_be_i     (req_be_i),
   .rsp_valid_o  (rsp_valid_o),
   .ecc_corr_o   (ecc_corr_o),
   .ecc_uncorr_o (ecc_uncorr_o)
);

// File: tb/ecc_sram_ctrl_tb_top.sv
`timescale 1ns/1ps
module ecc_sram_ctrl_tb_top;

   localparam int ADDR_W = 32;
   localparam int DATA_W = 128;
   localparam int DEPTH  = 64;
   localparam logic [127:0] ALL  = {128{1'b1}};
   localparam logic [127:0] LOW  = {{64{1'b0}}, {64{1'b1}}};

   logic                clk = 1'b0;
   logic                rst_ni;
   logic [ADDR_W-1:0]   cfg_base_i;
   logic                req_valid_i;
   logic                req_ready_o;
   logic                req_write_i;
   logic [ADDR_W-1:0]   req_addr_i;
   logic [15:0]         req_be_i;
   logic [DATA_W-1:0]   req_wdata_i;
   logic                rsp_valid_o;
   logic [DATA_W-1:0]   rsp_rdata_o;
   logic                ecc_corr_o;
   logic                ecc_uncorr_o;

   int n_tests = 0;
   int n_fail  = 0;

   typedef struct {
      logic [127:0] data;
      logic [127:0] mask;
      logic         corr;
      logic         unc;
      string        tag;
   } exp_t;

   exp_t rq[$];
   exp_t wq[$];
   logic [127:0] ref_mem [DEPTH];

   always #2 clk = ~clk;

   ecc_sram_ctrl dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_ni),
      .cfg_base_i   (cfg_base_i),
      .req_valid_i  (req_valid_i),
      .req_ready_o  (req_ready_o),
      .req_write_i  (req_write_i),
      .req_addr_i   (req_addr_i),
      .req_be_i     (req_be_i),
      .req_wdata_i  (req_wdata_i),
      .rsp_valid_o  (rsp_valid_o),
      .rsp_rdata_o  (rsp_rdata_o),
      .ecc_corr_o   (ecc_corr_o),
      .ecc_uncorr_o (ecc_uncorr_o)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // monitor: pops expected results in order as the design produces them
   always @(negedge clk) begin
      if (rst_ni) begin
         if (rsp_valid_o) begin
            if (rq.size() == 0) begin
               chk(1'b0, "R5", "unexpected response", rsp_rdata_o, '0);
            end else begin
               exp_t e;
               e = rq.pop_front();
               chk(((rsp_rdata_o ^ e.data) & e.mask) == '0, e.tag, "read data",
                   rsp_rdata_o & e.mask, e.data & e.mask);
               chk({ecc_corr_o, ecc_uncorr_o} == {e.corr, e.unc}, e.tag, "read flags",
                   {ecc_corr_o, ecc_uncorr_o}, {e.corr, e.unc});
            end
         end else if (ecc_corr_o || ecc_uncorr_o) begin
            if (wq.size() == 0) begin
               chk(1'b0, "R3", "unexpected flag", {ecc_corr_o, ecc_uncorr_o}, '0);
            end else begin
               exp_t e;
               e = wq.pop_front();
               chk({ecc_corr_o, ecc_uncorr_o} == {e.corr, e.unc}, e.tag, "write flags",
                   {ecc_corr_o, ecc_uncorr_o}, {e.corr, e.unc});
            end
         end
      end
   end

   function automatic logic [31:0] beat_addr(input int idx);
      return cfg_base_i + 32'(idx * 16);
   endfunction

   // one request; returns at the falling edge after the accepting edge
   task automatic send(input logic wr, input logic [31:0] a, input logic [15:0] be,
                       input logic [127:0] d, input logic exp_ready, input string tag);
      @(negedge clk);
      while (!req_ready_o) @(negedge clk);
      req_valid_i = 1'b1;
      req_write_i = wr;
      req_addr_i  = a;
      req_be_i    = be;
      req_wdata_i = d;
      @(negedge clk);
      req_valid_i = 1'b0;
      chk(req_ready_o == exp_ready, tag, "ready after accept", 128'(req_ready_o), 128'(exp_ready));
   endtask

   task automatic wr(input int idx, input logic [15:0] be, input logic [127:0] d,
                     input logic exp_ready, input logic fc, input logic fu, input string tag);
      exp_t e;
      if (fc || fu) begin
         e.data = '0; e.mask = '0; e.corr = fc; e.unc = fu; e.tag = tag;
         wq.push_back(e);
      end
      if (!fu) begin
         for (int b = 0; b < 16; b++) if (be[b]) ref_mem[idx][b*8 +: 8] = d[b*8 +: 8];
      end
      send(1'b1, beat_addr(idx), be, d, exp_ready, tag);
   endtask

   task automatic rd(input int idx, input logic [127:0] mask, input logic fc,
                     input logic fu, input string tag);
      exp_t e;
      e.data = ref_mem[idx]; e.mask = mask; e.corr = fc; e.unc = fu; e.tag = tag;
      rq.push_back(e);
      send(1'b0, beat_addr(idx), '0, '0, 1'b0, tag);
      chk(!rsp_valid_o, "R5", "no response after first edge", 128'(rsp_valid_o), 128'(0));
      @(negedge clk);
      chk(rsp_valid_o, "R5", "response after second edge", 128'(rsp_valid_o), 128'(1));
   endtask

   task automatic flip(input int idx, input int lane, input int bitpos);
      @(negedge clk);
      while (!req_ready_o) @(negedge clk);
      if (lane == 0) dut_i.u_array.g_lane[0].mem_q[idx][bitpos] = ~dut_i.u_array.g_lane[0].mem_q[idx][bitpos];
      else           dut_i.u_array.g_lane[1].mem_q[idx][bitpos] = ~dut_i.u_array.g_lane[1].mem_q[idx][bitpos];
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_ni      = 1'b1;
      cfg_base_i  = 32'h0001_0000;
      req_valid_i = 1'b0;
      req_write_i = 1'b0;
      req_addr_i  = '0;
      req_be_i    = '0;
      req_wdata_i = '0;
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
      #1 rst_ni = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11 reset state
      chk(req_ready_o && !rsp_valid_o && !ecc_corr_o && !ecc_uncorr_o, "R11", "reset outputs",
          {rsp_valid_o, ecc_corr_o, ecc_uncorr_o, req_ready_o}, 128'h1);
      rst_ni = 1'b1;

      // R1 / R3 full writes, read back
      wr(0, 16'hFFFF, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 1'b1, 0, 0, "R3");
      wr(1, 16'hFFFF, 128'hDEAD_BEEF_0BAD_F00D_CAFE_BABE_1357_9BDF, 1'b1, 0, 0, "R3");
      rd(0, ALL, 0, 0, "R1");
      rd(1, ALL, 0, 0, "R1");

      // R2 / R4 partial byte patterns
      wr(2, 16'hFFFF, 128'hA5A5_A5A5_A5A5_A5A5_5A5A_5A5A_5A5A_5A5A, 1'b1, 0, 0, "R3");
      wr(2, 16'h00F0, 128'h1111_2222_3333_4444_5555_6666_7777_8888, 1'b0, 0, 0, "R4");
      rd(2, ALL, 0, 0, "R2");
      wr(2, 16'h0F0F, 128'h9999_AAAA_BBBB_CCCC_DDDD_EEEE_FFFF_0000, 1'b0, 0, 0, "R4");
      wr(2, 16'h8001, 128'h7700_0000_0000_0000_0000_0000_0000_0066, 1'b0, 0, 0, "R2");
      rd(2, ALL, 0, 0, "R2");
      wr(2, 16'hFF00, 128'h0F0F_0F0F_F0F0_F0F0_0000_0000_0000_0000, 1'b1, 0, 0, "R3");
      rd(2, ALL, 0, 0, "R3");

      // R6 single-bit errors, not written back
      flip(1, 0, 5);
      rd(1, ALL, 1, 0, "R6");
      rd(1, ALL, 1, 0, "R6");
      wr(5, 16'hFFFF, 128'h5555_0000_AAAA_1111_2222_3333_4444_6666, 1'b1, 0, 0, "R3");
      flip(5, 1, 64);
      flip(5, 0, 0);
      rd(5, ALL, 1, 0, "R6");

      // R7 double-bit error on read
      wr(3, 16'hFFFF, 128'h3333_3333_3333_3333_4444_4444_4444_4444, 1'b1, 0, 0, "R3");
      flip(3, 1, 10);
      flip(3, 1, 20);
      rd(3, LOW, 0, 1, "R7");

      // R8 partial write aborted by an uncorrectable lane
      wr(3, 16'h01FF, 128'hEEEE_EEEE_EEEE_EEEE_FFFF_FFFF_FFFF_FFFF, 1'b0, 0, 1, "R8");
      rd(3, LOW, 0, 1, "R8");

      // R9 partial write repairs a correctable lane
      wr(4, 16'hFFFF, 128'h0000_1111_2222_3333_4444_5555_6666_7777, 1'b1, 0, 0, "R3");
      flip(4, 0, 70);
      wr(4, 16'h0003, 128'h0000_0000_0000_0000_0000_0000_0000_ABCD, 1'b0, 1, 0, "R9");
      rd(4, ALL, 0, 0, "R9");

      // R10 outside the window
      send(1'b1, 32'h0001_0400, 16'hFFFF, ALL, 1'b1, "R10");
      send(1'b1, 32'h0000_FFF0, 16'hFFFF, ALL, 1'b1, "R10");
      send(1'b0, 32'h0001_0800, 16'h0000, '0, 1'b1, "R10");
      @(negedge clk);
      chk(!rsp_valid_o && !ecc_corr_o && !ecc_uncorr_o, "R10", "no response outside window",
          {rsp_valid_o, ecc_corr_o, ecc_uncorr_o}, '0);
      rd(0, ALL, 0, 0, "R10");
      cfg_base_i = 32'h0004_0000;
      rd(1, ALL, 1, 0, "R10");
      send(1'b0, 32'h0001_0010, 16'h0000, '0, 1'b1, "R10");
      @(negedge clk);
      chk(!rsp_valid_o, "R10", "old window ignored", 128'(rsp_valid_o), '0);

      repeat (4) @(negedge clk);
      chk(rq.size() == 0 && wq.size() == 0, "R5", "pending expected results",
          128'(rq.size() + wq.size()), '0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule